// File: doc/BRIEF.md
# Image Unit Command Dispatcher

The dispatcher is the front end of an image decompression unit. Software writes a 32-bit command word. The top four bits select an operation and the remaining 28 bits are its argument. Two operations finish within the dispatcher itself: clearing the input stream and loading colour thresholds. These finish in one cycle and raise an interrupt request. The remaining operations are handed to external datapaths through a start, done and stall handshake. While one of them runs, the dispatcher holds a busy flag.

The dispatcher also keeps the status flags and the command result word. It stores the result of a variable-length decode in a fixed format and the full word of a fixed-length decode. It raises an interrupt when a command stalls for lack of input while the input DMA channel is stopped, and when a block decode ends on a start code or at the end of data. A control-register write sets the intra DC precision, rewriting the reserved value 3 to 1. The same write can carry a soft-reset bit that returns all command state to idle.

Top module: `img_cmd_dispatch`

## Requirements
- R1: After reset, busy, cmd_busy, err, ecd, scd, irq, op_start, fifo_clr, result and idp are all zero.
- R2: Every accepted command write clears ecd and scd in the following cycle.
- R3: Opcode 0 (clear) and opcode 9 (set threshold) never set busy. In the following cycle they pulse irq for one cycle. Opcode 0 also pulses fifo_clr. Opcodes 10 to 15 set neither busy nor irq.
- R4: Opcodes 1 to 8 set busy in the following cycle. In that cycle op_start pulses for one cycle, op_code carries the opcode and op_arg carries bits [27:0] of the command word.
- R5: On completion of opcode 3 (variable-length decode), result becomes op_value[15:0] with bit 16 set and bits [31:17] clear. On completion of opcode 4 (fixed-length decode), result becomes op_value. Completion of any other opcode leaves result unchanged. The table select of opcode 3 is bits [27:26] of the command and reaches the datapath through op_arg.
- R6: A stall while busy sets cmd_busy. It pulses irq only if in_dma_run is low.
- R7: On completion, ecd and scd take op_ecd and op_scd. Completion of opcode 2 (block decode) pulses irq if either of them is 1. Completion of other opcodes pulses no irq.
- R8: A control write stores bits [17:16] into idp, except that the value 3 is stored as 1.
- R9: A control write with bit 30 set clears busy, cmd_busy, err, ecd, scd and result, and pulses fifo_clr. idp is still written.
- R10: A command written while busy is ignored: op_code, op_arg and busy do not change. It sets err, which stays set until soft reset.
- R11: Busy and cmd_busy fall in the cycle after op_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 32 | Command word, opcode in [31:28] |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 32 | Control word: [30] soft reset, [17:16] DC precision |
| in_dma_run | input | 1 | Input DMA channel is running |
| op_done | input | 1 | Datapath finished the current operation |
| op_stall | input | 1 | Datapath waits for input |
| op_value | input | 32 | Datapath result value |
| op_scd | input | 1 | Start code found, valid with op_done |
| op_ecd | input | 1 | End of data found, valid with op_done |
| op_start | output | 1 | One-cycle launch pulse |
| op_code | output | 4 | Opcode of the launched operation |
| op_arg | output | 28 | Argument of the launched operation |
| busy | output | 1 | An operation is running |
| cmd_busy | output | 1 | Command register busy bit, set on stall |
| result | output | 32 | Command result word |
| idp | output | 2 | Stored DC precision |
| ecd | output | 1 | End-of-data flag |
| scd | output | 1 | Start-code flag |
| err | output | 1 | Sticky command-while-busy flag |
| irq | output | 1 | One-cycle interrupt request |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |

## Verification
The bench sweeps all sixteen opcodes, each preceded by a block decode that leaves both flags set. A design that failed to clear ecd and scd on a new command, or that classified an opcode wrongly, would then show stale flags, a missing irq or a spurious start. All four variable-length table selects and all four precision values are exercised. A design that dropped the forced bit 16, or stored precision 3 unchanged, would give the wrong result or idp. Stalls are driven with the DMA channel both running and stopped, and a command is written while busy. A design that raised irq on every stall, or accepted the second command, would be caught.

// File: rtl/img_cmd_pkg.sv
package img_cmd_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_CLEAR = 4'd0;
  localparam logic [OPC_W-1:0] OPC_IDEC  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_BDEC  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_VDEC  = 4'd3;
  localparam logic [OPC_W-1:0] OPC_FDEC  = 4'd4;
  localparam logic [OPC_W-1:0] OPC_PACK  = 4'd8;
  localparam logic [OPC_W-1:0] OPC_THR   = 4'd9;

  typedef enum logic [1:0] {
    CLS_NOP = 2'd0,
    CLS_IMM = 2'd1,
    CLS_RUN = 2'd2
  } cmd_cls_t;
endpackage

// File: rtl/img_cmd_decode.sv
module img_cmd_decode
  import img_cmd_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output cmd_cls_t         cls,
  output logic             clr_fifo
);
  always_comb begin
    clr_fifo = (opc == OPC_CLEAR);
    if (opc == OPC_CLEAR || opc == OPC_THR)
      cls = CLS_IMM;
    else if (opc >= OPC_IDEC && opc <= OPC_PACK)
      cls = CLS_RUN;
    else
      cls = CLS_NOP;
  end
endmodule

// File: rtl/img_ctl_reg.sv
module img_ctl_reg #(
  parameter int DATA_W  = 32,
  parameter int IDP_W   = 2,
  parameter int IDP_LSB = 16,
  parameter int RST_BIT = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_data,
  output logic              soft_rst,
  output logic [IDP_W-1:0]  idp
);
  localparam logic [IDP_W-1:0] IDP_BAD = '1;
  localparam logic [IDP_W-1:0] IDP_FIX = 1;

  logic [IDP_W-1:0] idp_in;

  assign idp_in   = ctl_data[IDP_LSB +: IDP_W];
  assign soft_rst = ctl_wr & ctl_data[RST_BIT];

  always_ff @(posedge clk) begin
    if (rst)
      idp <= '0;
    else if (ctl_wr)
      idp <= (idp_in == IDP_BAD) ? IDP_FIX : idp_in;
  end

  // R8
  idp_legal_chk: assert property (@(posedge clk) disable iff (rst)
    idp != IDP_BAD);
endmodule

// File: rtl/img_result_fmt.sv
module img_result_fmt
  import img_cmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VAL_W  = 16
) (
  input  logic [OPC_W-1:0]  code,
  input  logic [DATA_W-1:0] value,
  output logic              we,
  output logic [DATA_W-1:0] word
);
  localparam int HI_W = DATA_W - VAL_W - 1;

  always_comb begin
    we   = 1'b0;
    word = value;
    if (code == OPC_VDEC) begin
      we   = 1'b1;
      word = {{HI_W{1'b0}}, 1'b1, value[VAL_W-1:0]};
    end else if (code == OPC_FDEC) begin
      we = 1'b1;
    end
  end
endmodule

// File: rtl/img_cmd_dispatch.sv
module img_cmd_dispatch
  import img_cmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int VAL_W   = 16,
  parameter int IDP_W   = 2,
  parameter int IDP_LSB = 16,
  parameter int RST_BIT = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_data,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_data,
  input  logic              in_dma_run,
  input  logic              op_done,
  input  logic              op_stall,
  input  logic [31:0]       op_value,
  input  logic              op_scd,
  input  logic              op_ecd,
  output logic              op_start,
  output logic [3:0]        op_code,
  output logic [27:0]       op_arg,
  output logic              busy,
  output logic              cmd_busy,
  output logic [31:0]       result,
  output logic [1:0]        idp,
  output logic              ecd,
  output logic              scd,
  output logic              err,
  output logic              irq,
  output logic              fifo_clr
);
  localparam int ARG_W = DATA_W - OPC_W;

  cmd_cls_t          cls;
  logic              cls_clr;
  logic              soft_rst;
  logic              fmt_we;
  logic [DATA_W-1:0] fmt_word;
  logic [OPC_W-1:0]  opc_in;

  assign opc_in = cmd_data[DATA_W-1 -: OPC_W];

  img_cmd_decode u_dec (
    .opc      (opc_in),
    .cls      (cls),
    .clr_fifo (cls_clr)
  );

  img_ctl_reg #(
    .DATA_W (DATA_W), .IDP_W (IDP_W), .IDP_LSB (IDP_LSB), .RST_BIT (RST_BIT)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_data (ctl_data),
    .soft_rst (soft_rst),
    .idp      (idp)
  );

  img_result_fmt #(.DATA_W (DATA_W), .VAL_W (VAL_W)) u_fmt (
    .code  (op_code),
    .value (op_value),
    .we    (fmt_we),
    .word  (fmt_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_start <= 1'b0;
      op_code  <= '0;
      op_arg   <= '0;
      busy     <= 1'b0;
      cmd_busy <= 1'b0;
      result   <= '0;
      ecd      <= 1'b0;
      scd      <= 1'b0;
      err      <= 1'b0;
      irq      <= 1'b0;
      fifo_clr <= 1'b0;
    end else begin
      op_start <= 1'b0;
      irq      <= 1'b0;
      fifo_clr <= 1'b0;
      if (soft_rst) begin
        busy     <= 1'b0;
        cmd_busy <= 1'b0;
        result   <= '0;
        ecd      <= 1'b0;
        scd      <= 1'b0;
        err      <= 1'b0;
        fifo_clr <= 1'b1;
      end else begin
        if (cmd_wr) begin
          if (busy) begin
            err <= 1'b1;
          end else begin
            ecd     <= 1'b0;
            scd     <= 1'b0;
            op_code <= opc_in;
            op_arg  <= cmd_data[ARG_W-1:0];
            case (cls)
              CLS_IMM: begin
                irq      <= 1'b1;
                fifo_clr <= cls_clr;
              end
              CLS_RUN: begin
                busy     <= 1'b1;
                op_start <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        if (busy) begin
          if (op_done) begin
            busy     <= 1'b0;
            cmd_busy <= 1'b0;
            ecd      <= op_ecd;
            scd      <= op_scd;
            if (fmt_we) result <= fmt_word;
            if (op_code == OPC_BDEC && (op_ecd || op_scd)) irq <= 1'b1;
          end else if (op_stall) begin
            cmd_busy <= 1'b1;
            if (!in_dma_run) irq <= 1'b1;
          end
        end
      end
    end
  end

  // R4
  launch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> op_start);

  // R3
  imm_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy && !soft_rst && cls == CLS_IMM) |=> (irq && !busy));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy && !soft_rst) |=> ($stable(op_code) && $stable(op_arg) && err));

  // R6
  stall_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_done && op_stall && !in_dma_run && !soft_rst) |=> (irq && cmd_busy));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && op_done && !soft_rst) |=> (!busy && !cmd_busy));
endmodule

// File: tb/img_cmd_dispatch_bench.sv
module img_cmd_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_data = '0;
  logic        in_dma_run = 1'b0;
  logic        op_done = 1'b0;
  logic        op_stall = 1'b0;
  logic [31:0] op_value = '0;
  logic        op_scd = 1'b0;
  logic        op_ecd = 1'b0;
  logic        op_start, busy, cmd_busy, ecd, scd, err, irq, fifo_clr;
  logic [3:0]  op_code;
  logic [27:0] op_arg;
  logic [31:0] result;
  logic [1:0]  idp;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_res = '0;

  always #10 clk = ~clk;

  img_cmd_dispatch u_img_cmd_dispatch (
    .clk, .rst, .cmd_wr, .cmd_data, .ctl_wr, .ctl_data, .in_dma_run,
    .op_done, .op_stall, .op_value, .op_scd, .op_ecd,
    .op_start, .op_code, .op_arg, .busy, .cmd_busy, .result, .idp,
    .ecd, .scd, .err, .irq, .fifo_clr
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_cmd(input logic [31:0] d);
    @(negedge clk); cmd_wr = 1'b1; cmd_data = d;
    tick();
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic send_ctl(input logic [31:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_data = d;
    tick();
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic finish_op(input logic [31:0] v, input logic s, input logic e);
    @(negedge clk); op_done = 1'b1; op_value = v; op_scd = s; op_ecd = e;
    tick();
    @(negedge clk); op_done = 1'b0; op_scd = 1'b0; op_ecd = 1'b0;
  endtask

  task automatic stall_op(input logic dma);
    @(negedge clk); op_stall = 1'b1; in_dma_run = dma;
    tick();
    @(negedge clk); op_stall = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    @(negedge clk); rst = 1'b0;
    tick();
    check("R1 busy", busy, 0);
    check("R1 flags", {cmd_busy, err, ecd, scd, irq, op_start, fifo_clr}, 0);
    check("R1 result", result, 0);
    check("R1 idp", idp, 0);

    // R7: flag combinations on block decode completion
    for (int c = 0; c < 4; c++) begin
      send_cmd({4'd2, 28'h0});
      finish_op(32'h0, c[0], c[1]);
      check("R7 scd", scd, c[0]);
      check("R7 ecd", ecd, c[1]);
      check("R7 irq", irq, (c != 0));
    end

    // R2 R3 R4 R5 R11: sweep every opcode
    for (int o = 0; o < 16; o++) begin
      logic [27:0] arg;
      logic [31:0] v;
      arg = 28'h0A5_5A00 ^ 28'(o * 28'h0111);
      v = 32'hDEAD_0000 | 32'(o * 32'h1357);
      send_cmd({4'd2, 28'h0});
      finish_op(32'h0, 1'b1, 1'b1);
      send_cmd({o[3:0], arg});
      check("R2 ecd", ecd, 0);
      check("R2 scd", scd, 0);
      if (o == 0 || o == 9) begin
        check("R3 busy", busy, 0);
        check("R3 irq", irq, 1);
        check("R3 fifo_clr", fifo_clr, (o == 0));
      end else if (o >= 1 && o <= 8) begin
        check("R4 busy", busy, 1);
        check("R4 op_start", op_start, 1);
        check("R4 op_code", op_code, o);
        check("R4 op_arg", op_arg, arg);
        finish_op(v, 1'b0, 1'b0);
        if (o == 3) exp_res = {15'd0, 1'b1, v[15:0]};
        else if (o == 4) exp_res = v;
        check("R5 result", result, exp_res);
        check("R11 busy", {busy, cmd_busy}, 0);
        check("R7 no irq", irq, 0);
      end else begin
        check("R3 nop busy", busy, 0);
        check("R3 nop irq", irq, 0);
      end
    end

    // R5: all four table selects of the variable-length decode
    for (int t = 0; t < 4; t++) begin
      logic [31:0] v;
      v = 32'hFFFF_0000 | 32'(t * 32'h4321);
      send_cmd({4'd3, t[1:0], 26'h15});
      check("R5 table", op_arg[27:26], t);
      finish_op(v, 1'b0, 1'b0);
      exp_res = {15'd0, 1'b1, v[15:0]};
      check("R5 vdec", result, exp_res);
    end
    send_cmd({4'd3, 26'h0, 2'b0});
    finish_op(32'h0, 1'b0, 1'b0);
    check("R5 zero value", result, 32'h0001_0000);

    // R6 R10: stalls and busy writes
    send_cmd({4'd1, 28'h123});
    stall_op(1'b0);
    check("R6 cmd_busy", cmd_busy, 1);
    check("R6 irq dma off", irq, 1);
    stall_op(1'b1);
    check("R6 irq dma on", irq, 0);
    send_cmd({4'd5, 28'h777});
    check("R10 err", err, 1);
    check("R10 op_code", op_code, 1);
    check("R10 op_arg", op_arg, 28'h123);
    finish_op(32'h0, 1'b0, 1'b0);
    check("R11 cleared", {busy, cmd_busy}, 0);
    check("R10 sticky", err, 1);

    // R8: DC precision
    for (int p = 0; p < 4; p++) begin
      send_ctl(32'(p) << 16);
      check("R8 idp", idp, (p == 3) ? 1 : p);
    end

    // R9: soft reset
    send_cmd({4'd7, 28'h0});
    stall_op(1'b1);
    send_ctl((32'd1 << 30) | (32'd2 << 16));
    check("R9 busy", {busy, cmd_busy, err, ecd, scd}, 0);
    check("R9 result", result, 0);
    check("R9 fifo_clr", fifo_clr, 1);
    check("R9 idp", idp, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule